// File: doc/BRIEF.md
# Byte-Lane Static Memory Functional Model

This block is a clocked, synthesizable stand-in for an asynchronous word-wide static memory. The memory has two independent byte lanes. It takes active-low select, read-gate, write and per-lane enable inputs. It samples them on a fast internal clock and decodes them into one mode per lane. It then either returns stored bytes with a per-lane drive flag or records a write. The drive flags take the place of tri-state pins: when a flag is low, its lane of `dout` is held at zero.

Each lane has a write sequencer with two states, `WS_IDLE` and `WS_OPEN`. The sequencer moves from `WS_IDLE` to `WS_OPEN` on the first clock edge at which the lane is in write mode. It stays in `WS_OPEN` and recaptures the address and data on every edge at which the lane is still in write mode. On the first edge at which the lane has left write mode, the sequencer returns to `WS_IDLE` and commits the last captured word. The per-lane decoder has four modes: `LM_DESEL`, `LM_OFF`, `LM_READ` and `LM_WRITE`. Reads are registered, so they have one clock of latency. A read that hits the word being committed on the same edge returns the new data.

The address width is a parameter. A full-size instance uses `ADDR_W = 15`, which gives 32768 words. The default is smaller to keep the elaboration small.

Top module: `sram_lane_model`

## Requirements
- R1: The array holds 2^ADDR_W words of two 8-bit lanes. Each address keeps its own contents, and the highest address 2^ADDR_W-1 is usable.
- R2: With `sel_n` high, both bits of `lane_drive` are 0 and `dout` is 0 one clock later, whatever the other controls are. No write starts while `sel_n` is high.
- R3: With `sel_n` low and `wr_n` high, `lane_drive` is 0 one clock later if `rd_gate_n` is high, or if both bits of `lane_en_n` are high.
- R4: A read (`sel_n`=0, `rd_gate_n`=0, `wr_n`=1) sets `lane_drive[l]` and puts the stored byte on its lane one clock later, for each lane whose `lane_en_n[l]` is 0. Lane 0 is `dout[7:0]` under `lane_en_n[0]`, and lane 1 is `dout[15:8]` under `lane_en_n[1]`. A lane that is not driven outputs 0.
- R5: While `sel_n` and `wr_n` are both low, `lane_drive` is 0 one clock later, whatever `rd_gate_n` is.
- R6: A lane is written only if its `lane_en_n` bit is low during the write. The other lane's byte at that address is unchanged.
- R7: A lane's write window is the run of clock edges at which `sel_n`, `wr_n` and that lane's enable are all low. The window ends when any one of these three signals goes high. The lane commits the address and data sampled on the last edge of the window. If `din` changes during the window, the last value wins.
- R8: With `wr_n` held low, pulsing the lane enables high between words writes several words to different addresses back to back.
- R9: A read of the address being committed on the same edge returns the newly written data.
- R10: Reset clears `lane_drive` and `dout` and discards an open write window, so the memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| rd_gate_n | input | 1 | Active-low output gate for reads |
| wr_n | input | 1 | Active-low write request |
| lane_en_n | input | LANES | Active-low per-lane enable; bit 0 is the low byte |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data; zero in lanes that are not driven |
| lane_drive | output | LANES | Per-lane flag that stands in for an enabled output driver |

## Verification
The stimulus covers every row of the control decode. It has select high combined with read and with write controls, gate high, both enables high, read on one lane and on both lanes, and write with the gate both low and high. Write windows are closed by each of the three terminating signals in turn, so a wrong commit condition shows up as a stale or missing word. A mid-window data change separates "last value wins" from "first value captured". Single-lane writes followed by single-lane reads expose cross-lane corruption. A read on the commit edge separates a bypassed read from a stale one. Reset is asserted inside an open window, which shows whether a pending write is dropped.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    // Per-lane decoded mode
    typedef enum logic [1:0] {
        LM_DESEL,
        LM_OFF,
        LM_READ,
        LM_WRITE
    } lane_mode_t;

    // Per-lane write sequencer
    typedef enum logic {
        WS_IDLE,
        WS_OPEN
    } wr_state_t;
endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
    import sram_lane_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             rd_gate_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_en_n,
    output lane_mode_t       mode [LANES]
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            if (sel_n) begin
                mode[l] = LM_DESEL;
            end else if (!wr_n) begin
                mode[l] = lane_en_n[l] ? LM_OFF : LM_WRITE;
            end else if (rd_gate_n || lane_en_n[l]) begin
                mode[l] = LM_OFF;
            end else begin
                mode[l] = LM_READ;
            end
        end
    end
endmodule

// File: rtl/sram_lane_writer.sv
module sram_lane_writer
    import sram_lane_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lane_mode_t    mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    wr_state_t state, state_nx;
    logic      in_window;

    assign in_window = (mode == LM_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE: if (in_window)  state_nx = WS_OPEN;
            WS_OPEN: if (!in_window) state_nx = WS_IDLE;
            default: state_nx = WS_IDLE;
        endcase
    end

    // Last sample of the window is the one committed
    always_ff @(posedge clk) begin
        if (in_window) begin
            commit_addr <= addr;
            commit_data <= din;
        end
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            WS_IDLE: commit = 1'b0;
            WS_OPEN: commit = !in_window;
            default: commit = 1'b0;
        endcase
    end

    // R7: a commit is always preceded by a cycle inside the window
    assert_commit_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(mode == LM_WRITE));

    // R8: each window yields exactly one commit
    assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    output logic          drive,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    assign hit = commit && (commit_addr == addr);

    always_ff @(posedge clk) begin
        if (commit) mem[commit_addr] <= commit_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
            dout  <= '0;
        end else begin
            drive <= rd_en;
            if (!rd_en)   dout <= '0;
            else if (hit) dout <= commit_data;
            else          dout <= mem[addr];
        end
    end

    // R9: a same-edge read of the committed word sees the new data
    assert_bypass_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit) |=> (dout == $past(commit_data)));

    // R4: an undriven lane outputs zero
    assert_quiet_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (dout == '0));
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      rd_gate_n,
    input  logic                      wr_n,
    input  logic [LANES-1:0]          lane_en_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic [LANES-1:0]          lane_drive
);
    localparam int DATA_W = LANES * LANE_W;

    lane_mode_t lane_mode [LANES];

    sram_ctl_decode #(.LANES(LANES)) u_decode (
        .sel_n     (sel_n),
        .rd_gate_n (rd_gate_n),
        .wr_n      (wr_n),
        .lane_en_n (lane_en_n),
        .mode      (lane_mode)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              commit;
        logic [ADDR_W-1:0] commit_addr;
        logic [LANE_W-1:0] commit_data;

        sram_lane_writer #(.AW(ADDR_W), .DW(LANE_W)) u_writer (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode        (lane_mode[g]),
            .addr        (addr),
            .din         (din[g*LANE_W +: LANE_W]),
            .commit      (commit),
            .commit_addr (commit_addr),
            .commit_data (commit_data)
        );

        sram_lane_store #(.AW(ADDR_W), .DW(LANE_W)) u_store (
            .clk         (clk),
            .rst_n       (rst_n),
            .rd_en       (lane_mode[g] == LM_READ),
            .addr        (addr),
            .commit      (commit),
            .commit_addr (commit_addr),
            .commit_data (commit_data),
            .drive       (lane_drive[g]),
            .dout        (dout[g*LANE_W +: LANE_W])
        );
    end

    // R2: deselect silences every lane
    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (lane_drive == '0 && dout == {DATA_W{1'b0}}));

    // R3: closed gate on a read cycle silences every lane
    assert_gate_closed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && rd_gate_n) |=> (lane_drive == '0));

    // R5: a write cycle never drives the outputs
    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> (lane_drive == '0));
endmodule

// File: tb/sram_lane_model_test.sv
`timescale 1ns/1ps
module sram_lane_model_test;
    localparam int AW = 10;
    localparam int NV = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, rd_gate_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  lane_en_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  lane_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sram_lane_model #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_gate_n(rd_gate_n),
        .wr_n(wr_n), .lane_en_n(lane_en_n), .addr(addr), .din(din),
        .dout(dout), .lane_drive(lane_drive)
    );

    // {sel_n, rd_gate_n, wr_n, en1_n, en0_n}, addr, din, expected drive, expected dout
    localparam logic [48:0] VEC [NV] = '{
        {5'b10000, 10'h005, 16'hFFFF, 2'b00, 16'h0000},
        {5'b01000, 10'h001, 16'hA1B2, 2'b00, 16'h0000},
        {5'b00000, 10'h001, 16'hC3D4, 2'b00, 16'h0000},
        {5'b00100, 10'h001, 16'h0000, 2'b11, 16'hC3D4},
        {5'b00100, 10'h001, 16'h0000, 2'b11, 16'hC3D4},
        {5'b01010, 10'h001, 16'h0011, 2'b00, 16'h0000},
        {5'b01011, 10'h001, 16'h0011, 2'b00, 16'h0000},
        {5'b00101, 10'h001, 16'h0000, 2'b10, 16'hC300},
        {5'b00110, 10'h001, 16'h0000, 2'b01, 16'h0011},
        {5'b01000, 10'h002, 16'h2222, 2'b00, 16'h0000},
        {5'b01011, 10'h002, 16'h2222, 2'b00, 16'h0000},
        {5'b01000, 10'h003, 16'h3333, 2'b00, 16'h0000},
        {5'b01011, 10'h003, 16'h3333, 2'b00, 16'h0000},
        {5'b01100, 10'h002, 16'h0000, 2'b00, 16'h0000},
        {5'b00100, 10'h002, 16'h0000, 2'b11, 16'h2222},
        {5'b00100, 10'h003, 16'h0000, 2'b11, 16'h3333},
        {5'b01000, 10'h004, 16'h4444, 2'b00, 16'h0000},
        {5'b11000, 10'h004, 16'h4444, 2'b00, 16'h0000},
        {5'b00100, 10'h004, 16'h0000, 2'b11, 16'h4444},
        {5'b00111, 10'h004, 16'h0000, 2'b00, 16'h0000},
        {5'b00100, 10'h001, 16'h0000, 2'b11, 16'hC311},
        {5'b10100, 10'h001, 16'h0000, 2'b00, 16'h0000},
        {5'b01000, 10'h3FF, 16'hFFEE, 2'b00, 16'h0000},
        {5'b00100, 10'h3FF, 16'h0000, 2'b11, 16'hFFEE},
        {5'b00100, 10'h003, 16'h0000, 2'b11, 16'h3333}
    };

    function automatic string row_tag(int i);
        case (i)
            0, 17, 21:            return "R2";
            1, 16:                return "R5";
            2, 6, 18:             return "R7";
            3, 23:                return "R9";
            4:                    return "R4";
            5, 7, 8:              return "R6";
            9, 10, 11, 12, 14, 15: return "R8";
            13, 19:               return "R3";
            default:              return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [1:0] exp_drv, logic [15:0] exp_dout);
        checks++;
        if (lane_drive !== exp_drv || dout !== exp_dout) begin
            fails++;
            $display("FAIL %s: drive=%b dout=%h expected drive=%b dout=%h",
                     tag, lane_drive, dout, exp_drv, exp_dout);
        end
    endtask

    task automatic apply(logic [4:0] c, logic [AW-1:0] a, logic [15:0] d);
        {sel_n, rd_gate_n, wr_n, lane_en_n} = c;
        addr = a;
        din  = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", 2'b00, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: row i applied, its result sampled one clock later
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][48:44], VEC[i][43:34], VEC[i][33:18]);
            @(negedge clk);
            check(row_tag(i), VEC[i][17:16], VEC[i][15:0]);
        end

        // R10: reset inside an open write window discards it
        apply(5'b01000, 10'h006, 16'h1111);
        @(negedge clk);
        apply(5'b11100, 10'h006, 16'h0000);
        @(negedge clk);
        apply(5'b01000, 10'h006, 16'h9999);
        @(negedge clk);
        rst_n = 1'b0;
        apply(5'b11100, 10'h006, 16'h0000);
        @(negedge clk);
        check("R10 held", 2'b00, 16'h0000);
        rst_n = 1'b1;
        apply(5'b00100, 10'h006, 16'h0000);
        @(negedge clk);
        check("R10 discard", 2'b11, 16'h1111);

        // R1: lower word still intact after all activity
        apply(5'b00100, 10'h002, 16'h0000);
        @(negedge clk);
        check("R1 retain", 2'b11, 16'h2222);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule